// File: doc/BRIEF.md
# Colour-Tagged Instruction Stream Filter

This block sits between an instruction prefetch pipeline and an execute stage. Both sides use valid/ready handshakes. Each fetched packet carries an instruction word, the program counter of that instruction and a one-bit colour tag. The filter keeps a local colour bit. A packet whose tag equals that colour passes straight through to the execute side with its own PC, so the execute side never has to read a PC from a stage that is not next to it. A packet whose tag differs is consumed and thrown away.

A taken branch arrives on a simple input port. It inverts the local colour and loads a one-entry request buffer. That buffer drives a separate valid/ready channel back to the prefetch unit, carrying the branch target and the new colour. The prefetch unit tags every later fetch with that colour. The filter never counts how many stale packets are still in flight: it drains stale packets until a packet of the current colour turns up. The request channel does not depend on the packet path, so a branch taken while the packet path is back-pressured cannot deadlock.

Top module: `colour_fetch_filter`

## Requirements
- R1: When an incoming packet's tag equals the effective colour, out_valid equals in_valid in the same cycle, out_insn and out_pc equal in_insn and in_pc, and in_ready equals out_ready.
- R2: The local colour is 0 after reset. Each cycle with br_taken=1 inverts it, and no other cycle changes it. The colour is visible as req_tag on every request the buffer raises.
- R3: One cycle after a cycle with br_taken=1, req_valid=1, req_target holds the br_target of that cycle and req_tag holds the inverted colour.
- R4: When a packet's tag differs from the effective colour, out_valid=0 and in_ready=1, so the packet is consumed in one cycle. Any number of such packets in a row are drained this way.
- R5: While req_valid=1 and req_ready=0 and no new branch arrives, req_valid, req_target and req_tag stay unchanged. req_valid drops in the cycle after a cycle with req_ready=1 and no branch.
- R6: A taken branch is accepted and its request is raised even while out_ready=0 and a matching packet is waiting.
- R7: A branch that arrives while an earlier request is still pending replaces that request's target and inverts the colour again.
- R8: The effective colour is the local colour XOR br_taken. A packet presented in the same cycle as a taken branch is therefore judged against the new colour.
- R9: Straight after reset, req_valid=0, and out_valid=0 while in_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Prefetch packet valid |
| in_ready | output | 1 | Filter accepts the packet |
| in_insn | input | DATA_W | Instruction word |
| in_pc | input | PC_W | PC of the instruction |
| in_tag | input | 1 | Colour tag of the packet |
| out_valid | output | 1 | Packet valid toward execute |
| out_ready | input | 1 | Execute accepts the packet |
| out_insn | output | DATA_W | Forwarded instruction word |
| out_pc | output | PC_W | Forwarded PC |
| br_taken | input | 1 | Taken branch strobe, one cycle per branch |
| br_target | input | PC_W | Branch target address |
| req_valid | output | 1 | New-stream request pending |
| req_ready | input | 1 | Prefetch accepts the request |
| req_target | output | PC_W | Start address of the new stream |
| req_tag | output | 1 | Colour the new stream must carry |

## Verification
Two things can fall in the same cycle: a taken branch and a packet waiting on the input. The packet must then be judged against the colour the branch creates, not the old one. The bench provokes this in directed steps, with a matching packet held under back-pressure while a branch arrives, and then in a long random phase with frequent branches. A behavioural model holds the colour and the pending request and works out the expected outputs every cycle. It also covers the case of a new branch landing on a request that is still pending, both with and without req_ready high in that same cycle.

// File: rtl/cfilt_pkg.sv
package cfilt_pkg;
  // colour in force during a cycle: a taken branch takes effect at once
  function automatic logic eff_colour(input logic local_c, input logic br);
    return local_c ^ br;
  endfunction

  function automatic logic tag_hit(input logic tag, input logic colour);
    return tag == colour;
  endfunction
endpackage

// File: rtl/cfilt_colour.sv
module cfilt_colour
  import cfilt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic br_taken,
  output logic colour_q,
  output logic colour_eff
);
  always_ff @(posedge clk) begin
    if (!rst_n) colour_q <= 1'b0;
    else        colour_q <= eff_colour(colour_q, br_taken);
  end
  assign colour_eff = eff_colour(colour_q, br_taken);
endmodule

// File: rtl/cfilt_steer.sv
module cfilt_steer
  import cfilt_pkg::*;
(
  input  logic in_valid,
  input  logic in_tag,
  input  logic colour_eff,
  input  logic out_ready,
  output logic out_valid,
  output logic in_ready,
  output logic drop_evt,
  output logic fwd_evt
);
  logic hit;
  always_comb begin
    hit       = tag_hit(in_tag, colour_eff);
    out_valid = in_valid & hit;
    in_ready  = out_ready | ~hit;
    drop_evt  = in_valid & ~hit;
    fwd_evt   = in_valid & hit & out_ready;
  end
endmodule

// File: rtl/cfilt_reqbuf.sv
module cfilt_reqbuf #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_target,
  input  logic            load_tag,
  input  logic            req_ready,
  output logic            req_valid,
  output logic [PC_W-1:0] req_target,
  output logic            req_tag,
  output logic            req_fire
);
  assign req_fire = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_target <= '0;
      req_tag    <= 1'b0;
    end else if (load) begin
      req_valid  <= 1'b1;
      req_target <= load_target;
      req_tag    <= load_tag;
    end else if (req_fire) begin
      req_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/colour_fetch_filter.sv
module colour_fetch_filter #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_insn,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_insn,
  output logic [PC_W-1:0]   out_pc,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PC_W-1:0]   req_target,
  output logic              req_tag
);
  logic colour_q, colour_eff;
  logic drop_evt, fwd_evt, req_fire;

  cfilt_colour u_colour (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken),
    .colour_q(colour_q), .colour_eff(colour_eff)
  );

  cfilt_steer u_steer (
    .in_valid(in_valid), .in_tag(in_tag), .colour_eff(colour_eff),
    .out_ready(out_ready), .out_valid(out_valid), .in_ready(in_ready),
    .drop_evt(drop_evt), .fwd_evt(fwd_evt)
  );

  cfilt_reqbuf #(.PC_W(PC_W)) u_req (
    .clk(clk), .rst_n(rst_n), .load(br_taken), .load_target(br_target),
    .load_tag(colour_eff), .req_ready(req_ready), .req_valid(req_valid),
    .req_target(req_target), .req_tag(req_tag), .req_fire(req_fire)
  );

  // each packet carries its own PC; the data path is a straight wire
  assign out_insn = in_insn;
  assign out_pc   = in_pc;
endmodule

// File: rtl/colour_fetch_filter_chk.sv
module colour_fetch_filter_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_tag,
  input logic            out_valid,
  input logic            out_ready,
  input logic            br_taken,
  input logic [PC_W-1:0] br_target,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PC_W-1:0] req_target,
  input logic            req_tag,
  input logic            colour_q,
  input logic            drop_evt,
  input logic            fwd_evt
);
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !br_taken && in_tag == colour_q) |-> (out_valid && in_ready == out_ready));

  p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (colour_q != $past(colour_q)));

  p_hold_colour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> $stable(colour_q));

  p_branch_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (req_valid && req_target == $past(br_target) && req_tag == colour_q));

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !br_taken && in_tag != colour_q) |-> (in_ready && !out_valid && drop_evt));

  p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !br_taken) |=>
      (req_valid && $stable(req_target) && $stable(req_tag)));

  p_no_deadlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && out_valid && !out_ready) |=> req_valid);

  p_single_fate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_evt && fwd_evt));
endmodule

bind colour_fetch_filter colour_fetch_filter_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
  .br_taken(br_taken), .br_target(br_target), .req_valid(req_valid),
  .req_ready(req_ready), .req_target(req_target), .req_tag(req_tag),
  .colour_q(colour_q), .drop_evt(drop_evt), .fwd_evt(fwd_evt)
);

// File: tb/colour_fetch_filter_tb_top.sv
module colour_fetch_filter_tb_top;
  localparam int DW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_tag, out_valid, out_ready;
  logic          br_taken, req_valid, req_ready, req_tag;
  logic [DW-1:0] in_insn, out_insn;
  logic [PW-1:0] in_pc, out_pc, br_target, req_target;

  colour_fetch_filter #(.DATA_W(DW), .PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_pc(in_pc), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_insn(out_insn), .out_pc(out_pc),
    .br_taken(br_taken), .br_target(br_target), .req_valid(req_valid),
    .req_ready(req_ready), .req_target(req_target), .req_tag(req_tag)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  // reference state
  bit m_col = 0, m_rv = 0, m_rtag = 0;
  logic [PW-1:0] m_rt = '0;
  string m_lab = "R3";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit iv, bit it, logic [DW-1:0] ins, logic [PW-1:0] pc,
                     bit ordy, bit br, logic [PW-1:0] bt, bit rrdy);
    bit eff, hit, held;
    string lo;
    in_valid = iv; in_tag = it; in_insn = ins; in_pc = pc;
    out_ready = ordy; br_taken = br; br_target = bt; req_ready = rrdy;
    #2;
    eff = m_col ^ br;
    hit = (it == eff);
    lo  = br ? (ordy ? "R8" : "R6") : (hit ? "R1" : "R4");
    chk(lo, out_valid, iv && hit);
    chk(lo, in_ready, ordy || !hit);
    if (iv && hit) begin
      chk(lo, out_insn, ins);
      chk(lo, out_pc, pc);
    end
    chk(m_lab, req_valid, m_rv);
    if (m_rv) begin
      chk(m_lab, req_target, m_rt);
      chk("R2", req_tag, m_rtag);
    end
    held = m_rv && !rrdy;
    if (br) begin
      m_lab = held ? "R7" : "R3";
      m_col = eff; m_rv = 1; m_rt = bt; m_rtag = eff;
    end else if (m_rv && rrdy) begin
      m_rv = 0; m_lab = "R5";
    end else if (m_rv) begin
      m_lab = "R5";
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_tag = 0; in_insn = '0; in_pc = '0;
    out_ready = 1; br_taken = 0; br_target = '0; req_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk("R9", req_valid, 0);
    chk("R9", out_valid, 0);
    @(posedge clk); #1;

    // R1: colour 0 stream passes, with and without back-pressure
    for (int i = 0; i < 6; i++)
      cyc(1, 0, 32'hA000 + i, 32'h100 + 4 * i, (i != 3), 0, '0, 0);

    // R6/R5: branch while execute stalls, request held until accepted
    cyc(1, 0, 32'hB0, 32'h200, 0, 1, 32'h8000, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'hB1, 32'h204, 0, 0, '0, 0);
    // R7: second branch overwrites pending request
    cyc(0, 0, '0, '0, 1, 1, 32'h9000, 0);
    cyc(0, 0, '0, '0, 1, 0, '0, 0);
    cyc(0, 0, '0, '0, 1, 0, '0, 1);
    // R4: stale tag-1 packets drained, then current colour 0 resumes
    for (int i = 0; i < 5; i++) cyc(1, 1, 32'hC0 + i, 32'h300 + 4 * i, 0, 0, '0, 0);
    cyc(1, 0, 32'hD0, 32'h9000, 1, 0, '0, 0);
    // R8: packet with the new colour in the branch cycle passes
    cyc(1, 1, 32'hE0, 32'h9004, 1, 1, 32'hA000, 1);
    cyc(1, 0, 32'hE1, 32'h9008, 1, 0, '0, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit br, it;
      br = ($urandom % 8) == 0;
      it = (($urandom % 4) == 0) ? ~m_col : m_col;
      cyc($urandom % 4 != 0, it, $urandom, $urandom, $urandom % 3 != 0,
          br, $urandom, $urandom % 2);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule